// File: doc/BRIEF.md
# Raster line interrupt generator

This block asks the CPU for an interrupt just before the video beam starts a chosen raster line. A video timing source supplies the beam's horizontal and vertical positions in pixel coordinates. Line 0 is the first line of visible pixels. Software programs a 9-bit target line, split across two byte-wide registers. The request is raised during the horizontal blank of the line before the target: it is high while the vertical count still shows that earlier line and the horizontal count lies in the window just past its pixel area. A handler therefore starts before the target line is drawn.

An external vertical offset moves the line numbering that the comparison uses. The legacy once-per-frame interrupt is merged into the same output, and a control bit can mask it. Reading the control register returns the live request level in its top bit. The enable and mask bits can also be reached through a separate two-bit alias port, and both write paths update the same flops.

Top module: `raster_line_irq`

## Requirements
- R1: The target line is 9 bits wide. Bit 8 is control register bit 0, and bits 7:0 come from the value register written on `val_we`.
- R2: Control bit 1 enables the line request. While it is 0, no line request reaches `irq`.
- R3: Control bit 2, when set, masks `frame_irq`. While it is clear, `irq` is high in the cycle after any cycle in which `frame_irq` is high.
- R4: Reset clears control bits 2:0, the value register and `irq`, so `ctl_rdata` reads 0 after reset.
- R5: Bits 7:3 of a control write must be 0. `ctl_rdata[6:3]` always reads 0, and `ctl_rdata[7]` reads the current level of `irq`.
- R6: The line request is high one cycle after a cycle in which all of the following hold: `vpos` equals the line before the effective target line, `hpos` lies in WIN_LO..WIN_HI (inclusive), and the line request is enabled. Outside the window it is low.
- R7: The effective target line is (target + `line_ofs`) mod TOTAL_LINES. An effective line of 0 fires on line TOTAL_LINES-1.
- R8: `alias_wdata[0]` writes the line enable and `alias_wdata[1]` writes the frame mask, into the same flops as control bits 1 and 2. `alias_rdata` reads them in that order. If both ports write in one cycle, the alias port wins for these bits.
- R9: The compare line is sampled only when `hpos` is 0. A register write made in the middle of a line does not change `irq` until the next line start, so `irq` has no pulse shorter than a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | HPOS_W | Horizontal beam position in pixels |
| vpos | input | VPOS_W | Vertical beam position in lines |
| line_ofs | input | VPOS_W | Vertical line numbering offset |
| frame_irq | input | 1 | Legacy once-per-frame interrupt request |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data with the live request level in bit 7 |
| val_we | input | 1 | Value register write strobe |
| val_wdata | input | 8 | Low byte of the target line |
| alias_we | input | 1 | Alias enable-bits write strobe |
| alias_wdata | input | 2 | Alias write data: bit 0 line enable, bit 1 frame mask |
| alias_rdata | output | 2 | Alias read data in the same layout |
| irq | output | 1 | Merged, registered interrupt request |

## Verification
The bench builds the block with its default 312-line frame and the 256..319 horizontal window. This makes targets above 255 reachable, so the ninth target bit has a real effect. A bench line with vertical count 43 separates a correct target of 300 from one that lost bit 8. The same frame size lets the wrap of target 0 onto line 311, and a target-plus-offset sum that passes the frame length, be checked directly. Because the bench drives the beam counters itself, it can place the beam on each edge of the window instead of walking whole frames.

// File: rtl/raster_line_irq.sv
module raster_line_irq #(
  parameter int HPOS_W      = 9,
  parameter int VPOS_W      = 9,
  parameter int TOTAL_LINES = 312,
  parameter int WIN_LO      = 256,
  parameter int WIN_HI      = 319
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HPOS_W-1:0] hpos,
  input  logic [VPOS_W-1:0] vpos,
  input  logic [VPOS_W-1:0] line_ofs,
  input  logic              frame_irq,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              val_we,
  input  logic [7:0]        val_wdata,
  input  logic              alias_we,
  input  logic [1:0]        alias_wdata,
  output logic [1:0]        alias_rdata,
  output logic              irq
);
  localparam int SUM_W = VPOS_W + 1;

  logic              tgt_hi, line_en, frame_mask;
  logic [7:0]        tgt_lo;
  logic [VPOS_W-1:0] cmp_line;
  logic              irq_q;

  wire [SUM_W-1:0]  line_sum = SUM_W'({tgt_hi, tgt_lo}) + SUM_W'(line_ofs);
  wire [SUM_W-1:0]  eff_line = line_sum % SUM_W'(TOTAL_LINES);
  wire [VPOS_W-1:0] pre_line = (eff_line == '0) ? VPOS_W'(TOTAL_LINES - 1)
                                                : VPOS_W'(eff_line - 1'b1);
  wire in_win   = (hpos >= HPOS_W'(WIN_LO)) && (hpos <= HPOS_W'(WIN_HI));
  wire line_hit = line_en && in_win && (vpos == cmp_line);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_hi     <= 1'b0;
      line_en    <= 1'b0;
      frame_mask <= 1'b0;
      tgt_lo     <= '0;
    end else begin
      if (ctl_we) begin
        tgt_hi     <= ctl_wdata[0];
        line_en    <= ctl_wdata[1];
        frame_mask <= ctl_wdata[2];
      end
      if (alias_we) begin
        line_en    <= alias_wdata[0];
        frame_mask <= alias_wdata[1];
      end
      if (val_we) tgt_lo <= val_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_line <= VPOS_W'(TOTAL_LINES - 1);
      irq_q    <= 1'b0;
    end else begin
      if (hpos == '0) cmp_line <= pre_line;
      irq_q <= line_hit || (frame_irq && !frame_mask);
    end
  end

  assign irq         = irq_q;
  assign ctl_rdata   = {irq_q, 4'b0000, frame_mask, line_en, tgt_hi};
  assign alias_rdata = {frame_mask, line_en};

  AST_RSVD_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |-> ctl_wdata[7:3] == 5'd0);                                       // R5
  AST_OUTSIDE_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_win && !frame_irq) |=> !irq);                                        // R6
  AST_LINE_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!alias_rdata[0] && !frame_irq) |=> !irq);                                // R2
  AST_FRAME_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_irq && !alias_rdata[1]) |=> irq);                                  // R3
  AST_ALIAS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    alias_we |=> alias_rdata == $past(alias_wdata));                          // R8
  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !alias_we) |=> ctl_rdata[2:0] == $past(ctl_wdata[2:0]));       // R1
  AST_HOLD_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos != '0) |=> $stable(cmp_line));                                      // R9
endmodule

// File: tb/raster_line_irq_bench.sv
module raster_line_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] hpos = '0, vpos = '0, line_ofs = '0;
  logic       frame_irq = 1'b0;
  logic       ctl_we = 1'b0, val_we = 1'b0, alias_we = 1'b0;
  logic [7:0] ctl_wdata = '0, val_wdata = '0;
  logic [1:0] alias_wdata = '0;
  logic [7:0] ctl_rdata;
  logic [1:0] alias_rdata;
  logic       irq;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  raster_line_irq u_raster_line_irq (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .line_ofs(line_ofs),
    .frame_irq(frame_irq), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .val_we(val_we), .val_wdata(val_wdata),
    .alias_we(alias_we), .alias_wdata(alias_wdata), .alias_rdata(alias_rdata),
    .irq(irq));

  // fields: target[39:31] offset[30:22] vpos[21:13] hpos[12:4] en fr mask exp
  localparam int NV = 15;
  localparam logic [39:0] VEC [NV] = '{
    {9'd5,   9'd0, 9'd4,   9'd256, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 window start
    {9'd5,   9'd0, 9'd4,   9'd319, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 window end
    {9'd5,   9'd0, 9'd4,   9'd255, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 before window
    {9'd5,   9'd0, 9'd4,   9'd320, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 after window
    {9'd5,   9'd0, 9'd5,   9'd300, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 target line itself
    {9'd5,   9'd0, 9'd4,   9'd300, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 disabled
    {9'd300, 9'd0, 9'd299, 9'd270, 1'b1, 1'b0, 1'b0, 1'b1}, // R1 high bit used
    {9'd300, 9'd0, 9'd43,  9'd270, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 no alias to 44
    {9'd0,   9'd0, 9'd311, 9'd290, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 wrap of line 0
    {9'd310, 9'd5, 9'd2,   9'd290, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 sum wraps
    {9'd3,   9'd4, 9'd6,   9'd290, 1'b1, 1'b0, 1'b0, 1'b1}, // R7 offset applied
    {9'd3,   9'd4, 9'd2,   9'd290, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 unshifted line
    {9'd5,   9'd0, 9'd100, 9'd10,  1'b0, 1'b1, 1'b0, 1'b1}, // R3 frame passes
    {9'd5,   9'd0, 9'd100, 9'd10,  1'b0, 1'b1, 1'b1, 1'b0}, // R3 frame masked
    {9'd5,   9'd0, 9'd4,   9'd300, 1'b1, 1'b1, 1'b1, 1'b1}  // R3 mask keeps line
  };

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_val(input logic [7:0] d);
    val_we = 1'b1; val_wdata = d;
    @(negedge clk);
    val_we = 1'b0;
  endtask

  task automatic line_start(input logic [8:0] v);
    hpos = '0; vpos = v; frame_irq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(ctl_rdata, 8'h00, "R4 ctl after reset");
    check({7'd0, irq}, 8'h00, "R4 irq after reset");

    for (int i = 0; i < NV; i++) begin
      logic [39:0] v;
      v = VEC[i];
      wr_ctl({5'd0, v[1], v[3], v[39]});
      wr_val(v[38:31]);
      line_ofs = v[30:22];
      line_start(9'd0);
      vpos = v[21:13]; hpos = v[12:4]; frame_irq = v[2];
      @(negedge clk);
      check({7'd0, irq}, {7'd0, v[0]}, $sformatf("R1/R2/R3/R6/R7 vector %0d", i));
      check({7'd0, ctl_rdata[7]}, {7'd0, v[0]}, $sformatf("R5 status bit vector %0d", i));
      frame_irq = 1'b0;
    end
    line_ofs = '0;

    // R5: reserved read as zero
    wr_ctl(8'h07);
    hpos = 9'd10;
    @(negedge clk);
    check(ctl_rdata, 8'h07, "R5 reserved bits read zero");

    // R8: alias path and shared flops
    wr_ctl(8'h00);
    alias_we = 1'b1; alias_wdata = 2'b01;
    @(negedge clk);
    alias_we = 1'b0;
    check(ctl_rdata, 8'h02, "R8 alias sets line enable");
    wr_ctl(8'h04);
    check({6'd0, alias_rdata}, 8'h02, "R8 ctl write seen on alias");
    ctl_we = 1'b1; ctl_wdata = 8'h00; alias_we = 1'b1; alias_wdata = 2'b11;
    @(negedge clk);
    ctl_we = 1'b0; alias_we = 1'b0;
    check(ctl_rdata, 8'h06, "R8 alias wins on collision");

    // R9: mid-line write does not cut the request
    wr_ctl(8'h02);
    wr_val(8'd5);
    line_start(9'd0);
    vpos = 9'd4; hpos = 9'd280;
    @(negedge clk);
    check({7'd0, irq}, 8'h01, "R9 request up before write");
    val_we = 1'b1; val_wdata = 8'd100; hpos = 9'd281;
    @(negedge clk);
    val_we = 1'b0; hpos = 9'd282;
    check({7'd0, irq}, 8'h01, "R9 held in write cycle");
    @(negedge clk);
    check({7'd0, irq}, 8'h01, "R9 held after write");
    line_start(9'd4);
    hpos = 9'd280;
    @(negedge clk);
    check({7'd0, irq}, 8'h00, "R9 new target after line start");

    // R4: reset clears the registers again
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(ctl_rdata, 8'h00, "R4 ctl after second reset");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(negedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired got=running exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule